// File: doc/BRIEF.md
# Card Interface Host Register Slave (I2C)

This block is the host-facing register port of a smart-card interface. It is an I2C slave with two 8-bit registers. A write frame loads the control register, which drives the rest of the interface. A read frame returns a status byte. That byte mixes live card levels with sticky event flags.

Reading the status byte has a side effect. Once the byte has been fully shifted out, every flag it reported is cleared. A flag whose event fires again during the read stays set for the next read. The presence-change and fault flags pull an active-low interrupt line while any of them is set. The two answer-timing flags are also cleared when a new card session starts.

SCL and SDA arrive unsynchronised and are sampled on the system clock. The slave only drives SDA low, and the bus wiring supplies the wired-AND. Three strap inputs set the low address bits, so up to eight of these slaves can share one bus.

Top module: `cardif_i2c_regs`

## Requirements
- R1: The slave address is {4'b1001, addrStrap ^ 3'b100}, which is 0x48 with the straps at 3'b100. An address byte is its 7 address bits MSB first, then R/W (0 = write, 1 = read). On a matching address the slave pulls SDA low in the ninth bit. On any other address it leaves SDA released for the rest of the frame and changes no register.
- R2: In a write frame, the 8 data bits that follow the acknowledged address are taken MSB first. They load the control register when the eighth bit's SCL falls. The slave then pulls SDA low for the acknowledge bit. `ctrlReg` changes at no other time.
- R3: In a read frame, the slave shifts the status byte out MSB first, starting right after the address acknowledge. The byte is captured when the address acknowledge clock falls. The slave releases SDA for the master's acknowledge bit.
- R4: After reset, `ctrlReg` is 0x00 and all sticky flags are clear. With `cardIoLevel` high and the other live inputs low, the status reads 0x04.
- R5: Status bits 0, 2 and 7 are the live values of `cardPresent`, `cardIoLevel` and `cardPowered`.
- R6: These status bits are sticky: bit 1 sets on any change of `cardPresent` from the previous clock (previous value resets to 0), bit 3 on `supplyFault`, and bit 4 on `overloadFault`. `irqN` is low exactly while bit 1, 3 or 4 is set.
- R7: Bits 5 and 6 are sticky on `muteEvt` and `earlyEvt`. They do not affect `irqN`. `sessionStart` clears them, unless their event fires in the same cycle.
- R8: A read clears the sticky bits it reported only when the eighth data bit's SCL falls. A bit whose event fires at or after the capture is kept.
- R9: A frame is recognised only after a START (SDA falling while SCL high). Bits clocked without a START are ignored. A STOP (SDA rising while SCL high) returns the slave to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaDriveLow | output | 1 | 1 pulls the data line low |
| addrStrap | input | 3 | Address strap levels |
| cardPresent | input | 1 | Card presence level |
| cardIoLevel | input | 1 | Card data line level |
| cardPowered | input | 1 | Card supply is on |
| supplyFault | input | 1 | Supply fault event pulse |
| overloadFault | input | 1 | Over-current or over-temperature event pulse |
| muteEvt | input | 1 | Card did not answer in time, pulse |
| earlyEvt | input | 1 | Card answered too early, pulse |
| sessionStart | input | 1 | New card session begins, pulse |
| ctrlReg | output | 8 | Control register |
| irqN | output | 1 | Active-low interrupt |

## Verification
Writes are sent to the strapped address, to a wrong address and after a strap change. This tells address decoding apart from a fixed match. A frame clocked without a START shows that framing, not bit counting, opens a transaction. Reads are taken in several cases: with idle inputs, after a presence edge, after fault pulses, with live levels changed, and with a fault pulse injected mid-byte. These separate the live bits from the sticky ones and show whether the clear waits for the full byte and spares a fresh event. Mute and early pulses are cleared once by a read and once by a session start. This shows that both paths clear them and that neither touches the interrupt.

// File: rtl/cardif_i2c_pkg.sv
package cardif_i2c_pkg;

  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 7;
  localparam int STRAP_W = 3;

  // status byte layout
  localparam int BIT_PRESENT  = 0;
  localparam int BIT_PRES_CHG = 1;
  localparam int BIT_IO       = 2;
  localparam int BIT_SUPPLY   = 3;
  localparam int BIT_OVERLOAD = 4;
  localparam int BIT_MUTE     = 5;
  localparam int BIT_EARLY    = 6;
  localparam int BIT_POWERED  = 7;

  localparam logic [DATA_W-1:0] STICKY_MASK  = 8'h7A;
  localparam logic [DATA_W-1:0] IRQ_MASK     = 8'h1A;
  localparam logic [DATA_W-1:0] SESSION_MASK = 8'h60;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_WAIT_STOP
  } busState_e;

  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startDet;
    logic stopDet;
  } busEvent_t;

  typedef struct packed {
    logic shiftIn;
    logic loadTx;
    logic shiftTx;
    logic commitCtrl;
    logic clearFlags;
    logic driveAck;
    logic driveData;
  } dpStrobe_t;

endpackage

// File: rtl/cardif_i2c_sync.sv
module cardif_i2c_sync
  import cardif_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  output busEvent_t busEv,
  output logic      sdaLevel
);

  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic sclPrev, sdaPrev;
  logic sclNow, sdaNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[SYNC_STAGES-1];
      sdaPrev <= sdaPipe[SYNC_STAGES-1];
    end
  end

  assign sclNow = sclPipe[SYNC_STAGES-1];
  assign sdaNow = sdaPipe[SYNC_STAGES-1];

  always_comb begin
    busEv.sclRise  = sclNow & ~sclPrev;
    busEv.sclFall  = ~sclNow & sclPrev;
    busEv.startDet = sclNow & sclPrev & sdaPrev & ~sdaNow;
    busEv.stopDet  = sclNow & sclPrev & ~sdaPrev & sdaNow;
  end

  assign sdaLevel = sdaNow;

endmodule

// File: rtl/cardif_i2c_ctrl.sv
module cardif_i2c_ctrl
  import cardif_i2c_pkg::*;
#(
  parameter int BYTE_BITS = DATA_W
) (
  input  logic      clk,
  input  logic      rstN,
  input  busEvent_t busEv,
  input  logic      addrMatch,
  input  logic      rwBit,
  output dpStrobe_t strb
);

  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_BITS);

  busState_e state, nextState;
  logic [CNT_W-1:0] bitCnt, nextCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= nextState;
      bitCnt <= nextCnt;
    end
  end

  always_comb begin
    nextState = state;
    nextCnt   = bitCnt;
    strb      = '0;
    strb.driveAck  = (state == ST_ADDR_ACK) || (state == ST_WACK);
    strb.driveData = (state == ST_RDATA);

    if (busEv.stopDet) begin
      nextState = ST_IDLE;
    end else if (busEv.startDet) begin
      nextState = ST_ADDR;
      nextCnt   = '0;
    end else begin
      case (state)
        ST_ADDR, ST_WDATA: begin
          if (busEv.sclRise && bitCnt < CNT_FULL) begin
            strb.shiftIn = 1'b1;
            nextCnt      = bitCnt + 1'b1;
          end
          if (busEv.sclFall && bitCnt == CNT_FULL) begin
            nextCnt = '0;
            if (state == ST_ADDR) begin
              nextState = addrMatch ? ST_ADDR_ACK : ST_WAIT_STOP;
            end else begin
              strb.commitCtrl = 1'b1;
              nextState       = ST_WACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (busEv.sclFall) begin
            nextCnt = '0;
            if (rwBit) begin
              strb.loadTx = 1'b1;
              nextState   = ST_RDATA;
            end else begin
              nextState = ST_WDATA;
            end
          end
        end
        ST_WACK: begin
          if (busEv.sclFall) nextState = ST_WAIT_STOP;
        end
        ST_RDATA: begin
          if (busEv.sclRise && bitCnt < CNT_FULL) nextCnt = bitCnt + 1'b1;
          if (busEv.sclFall) begin
            if (bitCnt == CNT_FULL) begin
              strb.clearFlags = 1'b1;
              nextState       = ST_WAIT_STOP;
            end else if (bitCnt != '0) begin
              strb.shiftTx = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cardif_i2c_datapath.sv
module cardif_i2c_datapath
  import cardif_i2c_pkg::*;
#(
  parameter logic [ADDR_W-1:0]  ADDR_BASE     = 7'h48,
  parameter logic [STRAP_W-1:0] STRAP_DEFAULT = 3'b100
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strb,
  input  logic               sdaLevel,
  input  logic [STRAP_W-1:0] addrStrap,
  input  logic               cardPresent,
  input  logic               cardIoLevel,
  input  logic               cardPowered,
  input  logic               supplyFault,
  input  logic               overloadFault,
  input  logic               muteEvt,
  input  logic               earlyEvt,
  input  logic               sessionStart,
  output logic [DATA_W-1:0]  ctrlReg,
  output logic               sdaDriveLow,
  output logic               irqN,
  output logic               addrMatch,
  output logic               rwBit
);

  localparam int SHIFT_CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] rxShift, txShift, ctrlQ;
  logic [DATA_W-1:0] stickyQ, snapQ, seenQ;
  logic [DATA_W-1:0] evVec, liveVec, statusNow, clrMask, sessMask;
  logic [ADDR_W-1:0] devAddr;
  logic presPrevQ, sdaLowQ;

  assign devAddr   = ADDR_BASE ^ {{(ADDR_W-STRAP_W){1'b0}}, addrStrap ^ STRAP_DEFAULT};
  assign addrMatch = (rxShift[DATA_W-1:1] == devAddr);
  assign rwBit     = rxShift[0];

  always_comb begin
    evVec = '0;
    evVec[BIT_PRES_CHG] = cardPresent ^ presPrevQ;
    evVec[BIT_SUPPLY]   = supplyFault;
    evVec[BIT_OVERLOAD] = overloadFault;
    evVec[BIT_MUTE]     = muteEvt;
    evVec[BIT_EARLY]    = earlyEvt;

    liveVec = '0;
    liveVec[BIT_PRESENT] = cardPresent;
    liveVec[BIT_IO]      = cardIoLevel;
    liveVec[BIT_POWERED] = cardPowered;

    statusNow = (stickyQ & STICKY_MASK) | liveVec;
    clrMask   = strb.clearFlags ? (snapQ & ~seenQ) : '0;
    sessMask  = sessionStart ? SESSION_MASK : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift   <= '0;
      txShift   <= '0;
      ctrlQ     <= '0;
      stickyQ   <= '0;
      snapQ     <= '0;
      seenQ     <= '0;
      presPrevQ <= 1'b0;
      sdaLowQ   <= 1'b0;
    end else begin
      presPrevQ <= cardPresent;
      if (strb.shiftIn) rxShift <= {rxShift[DATA_W-2:0], sdaLevel};
      if (strb.commitCtrl) ctrlQ <= rxShift;
      if (strb.loadTx) begin
        txShift <= statusNow;
        snapQ   <= stickyQ;
        seenQ   <= evVec;
      end else begin
        if (strb.shiftTx) txShift <= {txShift[DATA_W-2:0], 1'b0};
        seenQ <= seenQ | evVec;
      end
      stickyQ <= ((stickyQ & ~clrMask & ~sessMask) | evVec) & STICKY_MASK;
      sdaLowQ <= strb.driveAck | (strb.driveData & ~txShift[DATA_W-1]);
    end
  end

  assign ctrlReg     = ctrlQ;
  assign sdaDriveLow = sdaLowQ;
  assign irqN        = ~|(stickyQ & IRQ_MASK);

  // shifts since the last capture, used to check when the clear may happen
  logic [SHIFT_CNT_W-1:0] shiftsSinceLoad;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftsSinceLoad <= '0;
    else if (strb.loadTx) shiftsSinceLoad <= '0;
    else if (strb.shiftTx && shiftsSinceLoad != SHIFT_CNT_W'(DATA_W)) shiftsSinceLoad <= shiftsSinceLoad + 1'b1;
  end

  assert_ctrl_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commitCtrl |=> $stable(ctrlQ))
    else $error("control register changed without a commit");

  assert_irq_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((stickyQ & IRQ_MASK) != '0 && !strb.clearFlags) |=> !irqN)
    else $error("interrupt released while a flag was pending");

  assert_clear_after_full_byte_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearFlags |-> (shiftsSinceLoad == SHIFT_CNT_W'(DATA_W - 1)))
    else $error("flags cleared before the status byte was sent");

endmodule

// File: rtl/cardif_i2c_regs.sv
module cardif_i2c_regs
  import cardif_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  input  logic [STRAP_W-1:0] addrStrap,
  input  logic              cardPresent,
  input  logic              cardIoLevel,
  input  logic              cardPowered,
  input  logic              supplyFault,
  input  logic              overloadFault,
  input  logic              muteEvt,
  input  logic              earlyEvt,
  input  logic              sessionStart,
  output logic [DATA_W-1:0] ctrlReg,
  output logic              irqN
);

  busEvent_t busEv;
  dpStrobe_t strb;
  logic sdaLevel, addrMatch, rwBit;

  cardif_i2c_sync #(.SYNC_STAGES(2)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .busEv(busEv), .sdaLevel(sdaLevel)
  );

  cardif_i2c_ctrl #(.BYTE_BITS(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busEv(busEv),
    .addrMatch(addrMatch), .rwBit(rwBit), .strb(strb)
  );

  cardif_i2c_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaLevel(sdaLevel),
    .addrStrap(addrStrap), .cardPresent(cardPresent),
    .cardIoLevel(cardIoLevel), .cardPowered(cardPowered),
    .supplyFault(supplyFault), .overloadFault(overloadFault),
    .muteEvt(muteEvt), .earlyEvt(earlyEvt), .sessionStart(sessionStart),
    .ctrlReg(ctrlReg), .sdaDriveLow(sdaDriveLow), .irqN(irqN),
    .addrMatch(addrMatch), .rwBit(rwBit)
  );

  assert_release_after_stop_R9: assert property (@(posedge clk) disable iff (!rstN)
    busEv.stopDet |-> ##2 !sdaDriveLow)
    else $error("data line still held after STOP");

endmodule

// File: tb/cardif_i2c_regs_bench.sv
`timescale 1ns/1ps
module cardif_i2c_regs_bench;

  localparam int Q = 8;       // clocks per quarter bus bit
  localparam int LAT = 3;     // bus edge to register update

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, sclDrv, sdaMst, sdaLine, sdaDriveLow, irqN;
  logic [2:0] addrStrap;
  logic cardPresent, cardIoLevel, cardPowered;
  logic supplyFault, overloadFault, muteEvt, earlyEvt, sessionStart;
  logic [7:0] ctrlReg;

  assign sdaLine = sdaMst & ~sdaDriveLow;

  cardif_i2c_regs u_cardif_i2c_regs (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine),
    .sdaDriveLow(sdaDriveLow), .addrStrap(addrStrap),
    .cardPresent(cardPresent), .cardIoLevel(cardIoLevel), .cardPowered(cardPowered),
    .supplyFault(supplyFault), .overloadFault(overloadFault),
    .muteEvt(muteEvt), .earlyEvt(earlyEvt), .sessionStart(sessionStart),
    .ctrlReg(ctrlReg), .irqN(irqN)
  );

  int cyc = 0;
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // scheduled model actions: 0 commit control, 1 capture status, 2 clear read flags
  int pendCycle[$];
  int pendKind[$];
  int pendData[$];

  logic [7:0] mCtrl, mSticky, mSnap, mSeen, mTxExp;
  logic mPrevPres;

  always @(posedge clk) begin : refModel
    logic [7:0] ev, clr, sess;
    bit doLoad, doClear;
    cyc++;
    if (!rstN) begin
      mCtrl = 8'h00; mSticky = 8'h00; mSnap = 8'h00; mSeen = 8'h00;
      mTxExp = 8'h00; mPrevPres = 1'b0;
    end else begin
      ev = 8'h00;
      ev[1] = cardPresent ^ mPrevPres;
      ev[3] = supplyFault;
      ev[4] = overloadFault;
      ev[5] = muteEvt;
      ev[6] = earlyEvt;
      mPrevPres = cardPresent;
      doLoad = 0; doClear = 0;
      while (pendCycle.size() > 0 && pendCycle[0] <= cyc) begin
        int k, d;
        void'(pendCycle.pop_front());
        k = pendKind.pop_front();
        d = pendData.pop_front();
        if (k == 0) mCtrl = d[7:0];
        else if (k == 1) doLoad = 1;
        else doClear = 1;
      end
      clr  = doClear ? (mSnap & ~mSeen) : 8'h00;
      sess = sessionStart ? 8'h60 : 8'h00;
      if (doLoad) begin
        mTxExp = {cardPowered, mSticky[6:3], cardIoLevel, mSticky[1], cardPresent};
        mSnap  = mSticky;
        mSeen  = ev;
      end else begin
        mSeen = mSeen | ev;
      end
      mSticky = ((mSticky & ~clr & ~sess) | ev) & 8'h7A;
    end
  end

  // per-clock comparison of the register output and the interrupt
  always @(negedge clk) begin
    if (rstN && !done) begin
      compared += 2;
      if (ctrlReg !== mCtrl) begin
        mismatched++;
        $display("FAIL R2 ctrlReg cycle %0d actual %h expected %h", cyc, ctrlReg, mCtrl);
      end
      if (irqN !== ~|(mSticky & 8'h1A)) begin
        mismatched++;
        $display("FAIL R6 irqN cycle %0d actual %b expected %b", cyc, irqN, ~|(mSticky & 8'h1A));
      end
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] devAddrOf(input logic [2:0] s);
    return {4'b1001, s ^ 3'b100};
  endfunction

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic schedule(input int kind, input int data);
    pendCycle.push_back(cyc + LAT);
    pendKind.push_back(kind);
    pendData.push_back(data);
  endtask

  task automatic bitClock(input logic b, output logic smp, input int kind, input int data);
    sdaMst = b; waitQ();
    sclDrv = 1'b1; waitQ();
    smp = sdaLine; waitQ();
    sclDrv = 1'b0;
    if (kind >= 0) schedule(kind, data);
    waitQ();
  endtask

  task automatic busStart();
    sdaMst = 1'b1; waitQ();
    sclDrv = 1'b1; waitQ();
    sdaMst = 1'b0; waitQ();
    sclDrv = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaMst = 1'b0; waitQ();
    sclDrv = 1'b1; waitQ();
    sdaMst = 1'b1; waitQ(); waitQ();
  endtask

  task automatic sendByte(input logic [7:0] d, output logic ack,
                          input int endKind, input int ackKind);
    logic s;
    for (int i = 7; i >= 0; i--) bitClock(d[i], s, (i == 0) ? endKind : -1, d);
    bitClock(1'b1, ack, ackKind, 0);
  endtask

  task automatic doWrite(input logic [6:0] addr, input logic [7:0] data, input string req);
    logic a1, a2;
    bit hit;
    hit = (addr == devAddrOf(addrStrap));
    busStart();
    sendByte({addr, 1'b0}, a1, -1, -1);
    sendByte(data, a2, hit ? 0 : -1, -1);
    busStop();
    check({req, " R1 address ack"}, {7'd0, a1}, {7'd0, !hit});
    check({req, " R2 data ack"}, {7'd0, a2}, {7'd0, !hit});
  endtask

  task automatic pulse(input int which);
    case (which)
      0: supplyFault = 1'b1;
      1: overloadFault = 1'b1;
      2: muteEvt = 1'b1;
      3: earlyEvt = 1'b1;
      default: sessionStart = 1'b1;
    endcase
    @(negedge clk);
    supplyFault = 1'b0; overloadFault = 1'b0; muteEvt = 1'b0;
    earlyEvt = 1'b0; sessionStart = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic doRead(input string req, input int injectAt, input int injectWhich);
    logic a1, s, nack;
    logic [7:0] got;
    busStart();
    sendByte({devAddrOf(addrStrap), 1'b1}, a1, -1, 1);
    for (int i = 7; i >= 0; i--) begin
      if (i == injectAt) pulse(injectWhich);
      bitClock(1'b1, s, (i == 0) ? 2 : -1, 0);
      got[i] = s;
    end
    bitClock(1'b1, nack, -1, 0);
    busStop();
    check({req, " R1 read address ack"}, {7'd0, a1}, 8'h00);
    check({req, " R3 status byte"}, got, mTxExp);
    check({req, " R3 line released for master ack"}, {7'd0, nack}, 8'h01);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : stimulus
    logic s;
    rstN = 1'b0; sclDrv = 1'b1; sdaMst = 1'b1; addrStrap = 3'b100;
    cardPresent = 1'b0; cardIoLevel = 1'b1; cardPowered = 1'b0;
    supplyFault = 1'b0; overloadFault = 1'b0; muteEvt = 1'b0;
    earlyEvt = 1'b0; sessionStart = 1'b0;
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R4: reset values
    check("R4 ctrlReg after reset", ctrlReg, 8'h00);
    check("R4 irqN after reset", {7'd0, irqN}, 8'h01);
    doRead("R4 idle status", -1, 0);
    check("R4 idle status value", mTxExp, 8'h04);

    // R2: write at the strapped address
    doWrite(7'h48, 8'hA5, "R2 write A5");
    check("R2 ctrl after write", ctrlReg, 8'hA5);

    // R1: wrong address leaves everything alone
    doWrite(7'h4A, 8'h11, "R1 wrong address");
    check("R1 ctrl unchanged", ctrlReg, 8'hA5);

    // R9: bits without START are ignored
    begin
      logic [7:0] frame;
      logic a;
      frame = {7'h48, 1'b0};
      for (int i = 7; i >= 0; i--) bitClock(frame[i], s, -1, 0);
      bitClock(1'b1, a, -1, 0);
      check("R9 no ack without START", {7'd0, a}, 8'h01);
      for (int i = 7; i >= 0; i--) bitClock(1'b0, s, -1, 0);
      bitClock(1'b1, a, -1, 0);
      check("R9 no data ack without START", {7'd0, a}, 8'h01);
      busStop();
      check("R9 ctrl unchanged", ctrlReg, 8'hA5);
    end

    // R1: straps move the address
    addrStrap = 3'b101;
    repeat (4) @(negedge clk);
    doWrite(7'h49, 8'h3C, "R1 strap 101 match");
    doWrite(7'h48, 8'h77, "R1 strap 101 old address");
    check("R1 ctrl after strap writes", ctrlReg, 8'h3C);
    addrStrap = 3'b100;
    repeat (4) @(negedge clk);

    // R6: presence edge raises the interrupt, read clears it (R8)
    cardPresent = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 irq low after presence edge", {7'd0, irqN}, 8'h00);
    doRead("R6 presence read", -1, 0);
    check("R6 presence status", mTxExp, 8'h07);
    check("R8 irq released after read", {7'd0, irqN}, 8'h01);

    // R5 and R6: live levels and fault flags
    cardPowered = 1'b1; cardIoLevel = 1'b0;
    pulse(0); pulse(1);
    doRead("R5 faults and live bits", -1, 0);
    check("R5 faults status", mTxExp, 8'h99);

    // R8: event arriving mid-byte is kept for the next read
    doRead("R8 inject during read", 3, 0);
    check("R8 first read without fault", mTxExp, 8'h81);
    check("R8 irq still low", {7'd0, irqN}, 8'h00);
    doRead("R8 second read", -1, 0);
    check("R8 kept fault reported", mTxExp, 8'h89);

    // R7: mute and early are sticky, not on the interrupt
    pulse(2); pulse(3);
    check("R7 irq unaffected", {7'd0, irqN}, 8'h01);
    doRead("R7 mute early read", -1, 0);
    check("R7 mute early status", mTxExp, 8'hE1);
    pulse(2);
    pulse(4);
    doRead("R7 session cleared", -1, 0);
    check("R7 status after session start", mTxExp, 8'h81);

    // R6: falling presence edge
    cardPresent = 1'b0;
    repeat (4) @(negedge clk);
    doRead("R6 presence removal", -1, 0);
    check("R6 removal status", mTxExp, 8'h82);

    repeat (20) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule